// File: doc/BRIEF.md
# Address-Generation Interlock and Bypass Unit

This block sits beside the decode stage of an in-order pipeline. An instruction being decoded may name a base register and an index register for its address calculation. The block compares those names with the destination registers of the older instructions still in flight in four stages: address generate, translate, data fetch and execute. If any of those instructions will write a register that decode needs, the block raises a hold. The decode instruction then stays where it is until the producing instruction has moved on. The put-away stage is not checked, because the register file already returns the right value for an instruction that has reached it.

A mode input turns on forwarding from the execute stage. With forwarding on, an execute-stage instruction in its last execution cycle does not cause a hold. Instead, the block raises a select that steers the execute result into the base or index input of the address adder, one cycle before the register file could supply it. With forwarding off, every execute-stage match holds decode and both selects stay low. The hold and the selects are combinational from the current stage contents. A copy of the hold, registered with a synchronous reset, is also provided.

Top module: `agi_interlock_unit`

## Requirements
- R1: With no stage writing a register that decode uses, `dec_hold` and both selects are 0.
- R2: `dec_hold` is 1 when the address-generate, translate or data-fetch stage has its write flag at 1 and its 4-bit destination equals `dec_base_reg` while `dec_base_used` is 1.
- R3: `dec_hold` is 1 when one of those three stages writes a destination equal to `dec_index_reg` while `dec_index_used` is 1. Each stage is compared using its own destination field.
- R4: A stage whose write flag is 0 never raises `dec_hold`. A field whose use flag is 0 never raises `dec_hold` or a select.
- R5: A register match requires all 4 bits to be equal. Registers that differ in any single bit, including the top bit, do not match.
- R6: With `fwd_en` at 0, an execute-stage match raises `dec_hold` whatever the value of `ex_last`, and both selects are 0.
- R7: With `fwd_en` at 1, an execute-stage match with `ex_last` at 1 and no match in an older stage gives `dec_hold` 0. In that case `sel_ex_base` is 1 if the base field matched and `sel_ex_index` is 1 if the index field matched.
- R8: With `fwd_en` at 1, an execute-stage match with `ex_last` at 0 raises `dec_hold`.
- R9: Whenever `dec_hold` is 1, both selects are 0.
- R10: `dec_hold_q` equals the value `dec_hold` had at the previous rising clock edge. A synchronous active-high `rst` sets it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered hold |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | 1 enables forwarding from the execute stage |
| ag_wr | input | 1 | Address-generate stage writes a register |
| ag_dst | input | 4 | Address-generate destination register |
| tr_wr | input | 1 | Translate stage writes a register |
| tr_dst | input | 4 | Translate destination register |
| df_wr | input | 1 | Data-fetch stage writes a register |
| df_dst | input | 4 | Data-fetch destination register |
| ex_wr | input | 1 | Execute stage writes a register |
| ex_dst | input | 4 | Execute destination register |
| ex_last | input | 1 | Execute instruction is in its final cycle |
| dec_base_used | input | 1 | Decode instruction uses a base register |
| dec_base_reg | input | 4 | Decode base register |
| dec_index_used | input | 1 | Decode instruction uses an index register |
| dec_index_reg | input | 4 | Decode index register |
| dec_hold | output | 1 | Keep the instruction in decode |
| sel_ex_base | output | 1 | Route the execute result to the base operand |
| sel_ex_index | output | 1 | Route the execute result to the index operand |
| dec_hold_q | output | 1 | `dec_hold` delayed by one clock |

## Verification
The hold and the selects are combinational, so a wrong comparator, a wrong stage wiring or a wrong forwarding rule shows at the ports in the same cycle as the stimulus. A missing hold lets decode go ahead with a stale register. A spurious hold costs cycles. A select raised together with the hold would feed a result that is not yet valid. The only stored state is the registered hold, and any fault in it shows one edge later on `dec_hold_q`. Stimulus therefore places a matching register in each stage in turn, in both the base and the index field. It also uses values that differ in a single bit, and it covers both forwarding modes with `ex_last` high and low.

// File: rtl/agi_pkg.sv
package agi_pkg;

    localparam int REG_W    = 4;
    localparam int N_STAGES = 4;
    localparam int IDX_AG   = 0;
    localparam int IDX_TR   = 1;
    localparam int IDX_DF   = 2;
    localparam int IDX_EX   = N_STAGES - 1;

    typedef logic [REG_W-1:0] reg_id_t;

    typedef struct packed {
        logic    wr;
        reg_id_t dst;
    } stage_wr_t;

    typedef struct packed {
        logic    base_use;
        reg_id_t base;
        logic    index_use;
        reg_id_t index;
    } dec_src_t;

    typedef struct packed {
        logic base;
        logic index;
    } hit_t;

    function automatic logic id_eq(reg_id_t a, reg_id_t b);
        return ~|(a ^ b);
    endfunction

endpackage

// File: rtl/agi_stage_cmp.sv
module agi_stage_cmp
    import agi_pkg::*;
(
    input  stage_wr_t stg,
    input  dec_src_t  dec,
    output hit_t      hit
);
    always_comb begin
        hit.base  = stg.wr & dec.base_use  & id_eq(stg.dst, dec.base);
        hit.index = stg.wr & dec.index_use & id_eq(stg.dst, dec.index);
    end
endmodule

// File: rtl/agi_hazard_merge.sv
module agi_hazard_merge
    import agi_pkg::*;
#(
    parameter int NS = N_STAGES
) (
    input  hit_t [NS-1:0] hits,
    input  logic          fwd_en,
    input  logic          ex_last,
    output logic          hold,
    output logic          sel_base,
    output logic          sel_index
);
    localparam int EXI = NS - 1;

    logic older_hit;
    logic ex_hit;
    logic ex_blocks;
    logic can_fwd;

    always_comb begin
        older_hit = 1'b0;
        for (int i = 0; i < EXI; i++) begin
            older_hit = older_hit | hits[i].base | hits[i].index;
        end
        ex_hit    = hits[EXI].base | hits[EXI].index;
        can_fwd   = fwd_en & ex_last;
        ex_blocks = ex_hit & ~can_fwd;
        hold      = older_hit | ex_blocks;
        sel_base  = can_fwd & hits[EXI].base  & ~hold;
        sel_index = can_fwd & hits[EXI].index & ~hold;
    end
endmodule

// File: rtl/agi_hold_reg.sv
module agi_hold_reg (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end
endmodule

// File: rtl/agi_interlock_unit.sv
module agi_interlock_unit
    import agi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fwd_en,
    input  logic       ag_wr,
    input  logic [3:0] ag_dst,
    input  logic       tr_wr,
    input  logic [3:0] tr_dst,
    input  logic       df_wr,
    input  logic [3:0] df_dst,
    input  logic       ex_wr,
    input  logic [3:0] ex_dst,
    input  logic       ex_last,
    input  logic       dec_base_used,
    input  logic [3:0] dec_base_reg,
    input  logic       dec_index_used,
    input  logic [3:0] dec_index_reg,
    output logic       dec_hold,
    output logic       sel_ex_base,
    output logic       sel_ex_index,
    output logic       dec_hold_q
);
    stage_wr_t [N_STAGES-1:0] stages;
    hit_t      [N_STAGES-1:0] hits;
    dec_src_t                 dec;

    always_comb begin
        stages[IDX_AG] = '{wr: ag_wr, dst: ag_dst};
        stages[IDX_TR] = '{wr: tr_wr, dst: tr_dst};
        stages[IDX_DF] = '{wr: df_wr, dst: df_dst};
        stages[IDX_EX] = '{wr: ex_wr, dst: ex_dst};
        dec = '{base_use: dec_base_used, base: dec_base_reg,
                index_use: dec_index_used, index: dec_index_reg};
    end

    for (genvar s = 0; s < N_STAGES; s++) begin : g_cmp
        agi_stage_cmp u_cmp (
            .stg (stages[s]),
            .dec (dec),
            .hit (hits[s])
        );
    end

    agi_hazard_merge #(.NS(N_STAGES)) u_merge (
        .hits      (hits),
        .fwd_en    (fwd_en),
        .ex_last   (ex_last),
        .hold      (dec_hold),
        .sel_base  (sel_ex_base),
        .sel_index (sel_ex_index)
    );

    agi_hold_reg u_hold (
        .clk (clk),
        .rst (rst),
        .d   (dec_hold),
        .q   (dec_hold_q)
    );
endmodule

// File: rtl/agi_interlock_chk.sv
module agi_interlock_chk (
    input logic       clk,
    input logic       rst,
    input logic       fwd_en,
    input logic       ag_wr,
    input logic [3:0] ag_dst,
    input logic       tr_wr,
    input logic [3:0] tr_dst,
    input logic       df_wr,
    input logic [3:0] df_dst,
    input logic       ex_wr,
    input logic [3:0] ex_dst,
    input logic       ex_last,
    input logic       dec_base_used,
    input logic [3:0] dec_base_reg,
    input logic       dec_index_used,
    input logic [3:0] dec_index_reg,
    input logic       dec_hold,
    input logic       sel_ex_base,
    input logic       sel_ex_index,
    input logic       dec_hold_q
);
    // R2: older-stage base matches hold decode
    a_r2_older_base_holds: assert property (@(posedge clk) disable iff (rst)
        ((ag_wr && dec_base_used && ag_dst == dec_base_reg) ||
         (tr_wr && dec_base_used && tr_dst == dec_base_reg) ||
         (df_wr && dec_base_used && df_dst == dec_base_reg)) |-> dec_hold);

    // R3: older-stage index matches hold decode
    a_r3_older_index_holds: assert property (@(posedge clk) disable iff (rst)
        ((ag_wr && dec_index_used && ag_dst == dec_index_reg) ||
         (tr_wr && dec_index_used && tr_dst == dec_index_reg) ||
         (df_wr && dec_index_used && df_dst == dec_index_reg)) |-> dec_hold);

    // R6: no forwarding selects without forwarding mode
    a_r6_no_fwd_no_sel: assert property (@(posedge clk) disable iff (rst)
        !fwd_en |-> (!sel_ex_base && !sel_ex_index));

    // R8: an execute match not in its last cycle holds
    a_r8_ex_not_last_holds: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && ex_wr && !ex_last && dec_base_used && ex_dst == dec_base_reg)
        |-> dec_hold);

    // R7: a last-cycle execute base match without hold forwards
    a_r7_fwd_base: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && ex_wr && ex_last && dec_base_used && ex_dst == dec_base_reg && !dec_hold)
        |-> sel_ex_base);

    // R9: hold excludes any select
    a_r9_hold_blocks_sel: assert property (@(posedge clk) disable iff (rst)
        dec_hold |-> (!sel_ex_base && !sel_ex_index));

    // R10: registered hold follows the combinational hold by one edge
    a_r10_hold_delay: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (dec_hold_q == $past(dec_hold)));
endmodule

bind agi_interlock_unit agi_interlock_chk u_chk (.*);

// File: tb/agi_interlock_unit_test.sv
module agi_interlock_unit_test;

    typedef struct packed {
        logic [3:0] req;
        logic       fwd;
        logic       agw; logic [3:0] agd;
        logic       trw; logic [3:0] trd;
        logic       dfw; logic [3:0] dfd;
        logic       exw; logic [3:0] exd;
        logic       exl;
        logic       bu;  logic [3:0] br;
        logic       iu;  logic [3:0] ir;
        logic       e_hold; logic e_sb; logic e_si;
    } vec_t;

    localparam int NV = 22;
    // fields: req fwd | ag | tr | df | ex last | base | index | hold sb si
    localparam vec_t VECS [NV] = '{
        '{4'd1, 1'b1, 1'b0,4'h2, 1'b0,4'h2, 1'b0,4'h3, 1'b0,4'h3, 1'b1, 1'b1,4'h2, 1'b1,4'h3, 1'b0,1'b0,1'b0}, // R1
        '{4'd1, 1'b1, 1'b1,4'h5, 1'b1,4'h6, 1'b1,4'h7, 1'b1,4'h8, 1'b0, 1'b1,4'h2, 1'b1,4'h3, 1'b0,1'b0,1'b0}, // R1
        '{4'd2, 1'b0, 1'b1,4'h2, 1'b0,4'h0, 1'b0,4'h0, 1'b0,4'h0, 1'b0, 1'b1,4'h2, 1'b0,4'h0, 1'b1,1'b0,1'b0}, // R2 ag
        '{4'd2, 1'b0, 1'b0,4'h0, 1'b1,4'h2, 1'b0,4'h0, 1'b0,4'h0, 1'b0, 1'b1,4'h2, 1'b0,4'h0, 1'b1,1'b0,1'b0}, // R2 tr
        '{4'd2, 1'b1, 1'b0,4'h0, 1'b0,4'h0, 1'b1,4'hA, 1'b0,4'h0, 1'b0, 1'b1,4'hA, 1'b0,4'h0, 1'b1,1'b0,1'b0}, // R2 df
        '{4'd3, 1'b0, 1'b1,4'h3, 1'b0,4'h0, 1'b0,4'h0, 1'b0,4'h0, 1'b0, 1'b1,4'h1, 1'b1,4'h3, 1'b1,1'b0,1'b0}, // R3 ag
        '{4'd3, 1'b1, 1'b0,4'h0, 1'b1,4'h3, 1'b0,4'h9, 1'b0,4'h0, 1'b0, 1'b0,4'h0, 1'b1,4'h3, 1'b1,1'b0,1'b0}, // R3 tr
        '{4'd3, 1'b1, 1'b0,4'h0, 1'b1,4'hC, 1'b0,4'hF, 1'b0,4'h0, 1'b0, 1'b0,4'h0, 1'b1,4'hF, 1'b0,1'b0,1'b0}, // R3 tr own dst
        '{4'd3, 1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,4'h7, 1'b0,4'h0, 1'b0, 1'b0,4'h0, 1'b1,4'h7, 1'b1,1'b0,1'b0}, // R3 df
        '{4'd4, 1'b0, 1'b1,4'h2, 1'b0,4'h0, 1'b0,4'h0, 1'b0,4'h0, 1'b0, 1'b0,4'h2, 1'b0,4'h0, 1'b0,1'b0,1'b0}, // R4 base unused
        '{4'd4, 1'b0, 1'b0,4'h2, 1'b0,4'h2, 1'b0,4'h2, 1'b0,4'h2, 1'b0, 1'b1,4'h2, 1'b1,4'h2, 1'b0,1'b0,1'b0}, // R4 no writes
        '{4'd4, 1'b1, 1'b0,4'h0, 1'b1,4'h3, 1'b0,4'h0, 1'b0,4'h0, 1'b0, 1'b0,4'h0, 1'b0,4'h3, 1'b0,1'b0,1'b0}, // R4 index unused
        '{4'd4, 1'b1, 1'b0,4'h0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,4'h4, 1'b1, 1'b1,4'h4, 1'b0,4'h0, 1'b0,1'b0,1'b0}, // R4 ex no write
        '{4'd5, 1'b0, 1'b1,4'h9, 1'b1,4'hA, 1'b1,4'h4, 1'b0,4'h0, 1'b0, 1'b1,4'h1, 1'b1,4'h6, 1'b0,1'b0,1'b0}, // R5 one-bit diffs
        '{4'd5, 1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,4'h0, 1'b1,4'hE, 1'b0, 1'b1,4'h8, 1'b1,4'hF, 1'b0,1'b0,1'b0}, // R5 one-bit diffs
        '{4'd6, 1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,4'h4, 1'b1, 1'b1,4'h4, 1'b0,4'h0, 1'b1,1'b0,1'b0}, // R6 last
        '{4'd6, 1'b0, 1'b0,4'h0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,4'h4, 1'b0, 1'b0,4'h0, 1'b1,4'h4, 1'b1,1'b0,1'b0}, // R6 not last
        '{4'd7, 1'b1, 1'b0,4'h0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,4'h4, 1'b1, 1'b1,4'h4, 1'b1,4'h5, 1'b0,1'b1,1'b0}, // R7 base
        '{4'd7, 1'b1, 1'b0,4'h0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,4'h6, 1'b1, 1'b1,4'h2, 1'b1,4'h6, 1'b0,1'b0,1'b1}, // R7 index
        '{4'd7, 1'b1, 1'b0,4'h0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,4'h6, 1'b1, 1'b1,4'h6, 1'b1,4'h6, 1'b0,1'b1,1'b1}, // R7 both
        '{4'd8, 1'b1, 1'b0,4'h0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,4'h4, 1'b0, 1'b1,4'h4, 1'b0,4'h0, 1'b1,1'b0,1'b0}, // R8
        '{4'd9, 1'b1, 1'b1,4'h5, 1'b0,4'h0, 1'b0,4'h0, 1'b1,4'h4, 1'b1, 1'b1,4'h4, 1'b1,4'h5, 1'b1,1'b0,1'b0}  // R9
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fwd_en = 1'b0;
    logic       ag_wr = 1'b0, tr_wr = 1'b0, df_wr = 1'b0, ex_wr = 1'b0, ex_last = 1'b0;
    logic [3:0] ag_dst = '0, tr_dst = '0, df_dst = '0, ex_dst = '0;
    logic       dec_base_used = 1'b0, dec_index_used = 1'b0;
    logic [3:0] dec_base_reg = '0, dec_index_reg = '0;
    logic       dec_hold, sel_ex_base, sel_ex_index, dec_hold_q;

    int checks = 0;
    int failures = 0;
    logic prev_hold = 1'b0;

    always #4 clk = ~clk;

    agi_interlock_unit uut (.*);

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        fwd_en = v.fwd;
        ag_wr = v.agw; ag_dst = v.agd;
        tr_wr = v.trw; tr_dst = v.trd;
        df_wr = v.dfw; df_dst = v.dfd;
        ex_wr = v.exw; ex_dst = v.exd; ex_last = v.exl;
        dec_base_used = v.bu; dec_base_reg = v.br;
        dec_index_used = v.iu; dec_index_reg = v.ir;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        string tag;
        repeat (3) @(negedge clk);
        check("R10", "reset hold_q", dec_hold_q, 1'b0);
        check("R1", "reset idle hold", dec_hold, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check("R10", "hold_q delay", dec_hold_q, prev_hold);
            drive(VECS[i]);
            #1;
            tag = $sformatf("R%0d", VECS[i].req);
            check(tag, $sformatf("vec%0d hold", i), dec_hold, VECS[i].e_hold);
            check(tag, $sformatf("vec%0d sel_base", i), sel_ex_base, VECS[i].e_sb);
            check(tag, $sformatf("vec%0d sel_index", i), sel_ex_index, VECS[i].e_si);
            prev_hold = VECS[i].e_hold;
        end

        // R10: registered hold follows, then synchronous reset clears it
        @(negedge clk);
        check("R10", "hold_q after last vec", dec_hold_q, prev_hold);
        drive(VECS[2]);
        @(negedge clk);
        check("R10", "hold_q set", dec_hold_q, 1'b1);
        rst = 1'b1;
        #1;
        check("R10", "hold_q before reset edge", dec_hold_q, 1'b1);
        @(negedge clk);
        check("R10", "hold_q cleared by reset", dec_hold_q, 1'b0);
        check("R2", "comb hold during reset", dec_hold, 1'b1);
        rst = 1'b0;
        drive(VECS[0]);
        @(negedge clk);
        check("R10", "hold_q idle", dec_hold_q, 1'b0);

        // R9 with index forwarding candidate and an older base hazard
        drive('{4'd9, 1'b1, 1'b0,4'h0, 1'b0,4'h0, 1'b1,4'h3, 1'b1,4'h6, 1'b1,
                1'b1,4'h3, 1'b1,4'h6, 1'b1,1'b0,1'b0});
        #1;
        check("R9", "hold", dec_hold, 1'b1);
        check("R9", "sel_index blocked", sel_ex_index, 1'b0);

        // R5: top-bit difference only against execute in forwarding mode
        drive('{4'd5, 1'b1, 1'b0,4'h0, 1'b0,4'h0, 1'b0,4'h0, 1'b1,4'hB, 1'b1,
                1'b1,4'h3, 1'b0,4'h0, 1'b0,1'b0,1'b0});
        #1;
        check("R5", "no fwd on bit3 diff", sel_ex_base, 1'b0);
        check("R5", "no hold on bit3 diff", dec_hold, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule